// File: doc/BRIEF.md
# Multichannel Serial Audio Bus Multiplexer

This block gathers serial PCM audio from several stereo converters that share one bit clock and one left/right word clock, and each converter has its own data line. Every converter lane feeds a 16-bit shift register, MSB first. Each transition of the word clock, rising or falling, marks the end of one channel half. A single one-cycle start pulse, taken from both edges, then copies every lane's finished sample into a holding register.

A sequencer then places the held samples on one shared 16-bit parallel bus, one word per bit-clock cycle, in lane order. A one-cycle write strobe marks each word so that a downstream host FIFO can take it. All logic runs on the bit clock. If a new start pulse arrives while a burst is still in progress, the pulse is dropped and a sticky overrun flag is raised.

Top module: `audio_lane_mux`

## Requirements
- R1: A start is detected at each change of `wclk` in either direction. The sample a lane captures is made of the 16 `sdata` bits sampled on the 16 rising clock edges before the edge at which the new `wclk` level is first sampled. The earliest of those bits sits in bit 15 (MSB first).
- R2: When a start is accepted, all LANES samples are copied at once into holding registers. Shifting goes on without a break, so the bit sampled on the start edge becomes the MSB-side first bit of the next sample.
- R3: After an accepted start on edge E, the held words of lanes 0 to LANES-1 appear on `bus_data` in that order, one on each edge from E+1 to E+LANES. `bus_we` is high in each of those cycles.
- R4: `bus_we` is low in every cycle that does not carry a word from an accepted start, so each accepted start yields exactly LANES strobes.
- R5: A start is accepted when the sequencer is idle, or when it arrives LANES or more edges after the previous accepted start. A start exactly LANES edges later gives back-to-back bursts with no idle cycle between them.
- R6: A start that arrives fewer than LANES edges after the previous accepted start is ignored. It adds no words and does not disturb the burst in progress. It also sets `overrun` to 1, and `overrun` stays 1 until reset.
- R7: A synchronous active-low reset clears the shift registers, the stored word-clock level (to 0), the sequencer, `bus_we`, `bus_data` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; every register uses its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wclk | input | 1 | Left/right word clock; each of its edges closes one channel half |
| sdata | input | LANES | One serial data line per stereo converter |
| bus_data | output | 16 | Parallel word bus to the host FIFO |
| bus_we | output | 1 | One-cycle write strobe for each valid word on `bus_data` |
| overrun | output | 1 | Sticky flag: a start arrived while a burst could not accept it |

## Verification
The bound checker watches the sequencer handshake on every cycle. An accepted start must make the sequencer busy, and the strobe must follow the busy state with a one-cycle lag. A start that meets an idle sequencer must always be accepted, and any refused start must set the overrun flag, which must then stay set. Some properties can only be shown by the bench's scenarios, because they depend on the serial history: that each word carries the right 16 bits in MSB-first order, that the lanes come out in index order, and that the first word lands on the right cycle. The same holds for exactly-LANES back-to-back bursts and for a dropped start that leaves the words in flight intact.

// File: rtl/amux_pkg.sv
// Package: shared word width and word type for the lane multiplexer.
// Assumes every converter delivers 16-bit samples.
package amux_pkg;
    parameter int unsigned WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/amux_lane_shifter.sv
// Module: one serial lane. Shifts data in MSB first on every rising edge and
// copies the finished word into a holding register when capture is high.
// Assumes capture is a single-cycle pulse in the same clock domain.
module amux_lane_shifter
    import amux_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sdata,
    input  logic  capture,
    output word_t held
);
    word_t shreg;

    // Shift register: takes a new bit on every edge, never stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[WORD_W-2:0], sdata};
    end

    // Holding register: takes the word as it stood before this edge's shift.
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= '0;
        else if (capture) held <= shreg;
    end
endmodule

// File: rtl/amux_edge_pulse.sv
// Module: word-clock edge detector. Registers wclk once and flags any
// difference between the live and stored level as a one-cycle start.
// Assumes wclk changes away from the rising clock edge (synchronous source).
module amux_edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk,
    output logic start
);
    logic wclk_q;

    // Previous level of the word clock.
    always_ff @(posedge clk) begin
        if (!rst_n) wclk_q <= 1'b0;
        else        wclk_q <= wclk;
    end

    // Both edges give a start.
    always_comb start = wclk ^ wclk_q;
endmodule

// File: rtl/amux_sequencer.sv
// Module: burst sequencer. On an accepted start it issues the held words of
// lanes 0..LANES-1 on consecutive cycles with a one-cycle strobe each.
// Assumes the held words stay stable until the next accepted start.
module amux_sequencer
    import amux_pkg::*;
#(
    parameter int unsigned LANES = 4,
    localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  word_t [LANES-1:0]  held,
    output logic               accept,
    output logic               busy,
    output word_t              bus_data,
    output logic               bus_we,
    output logic               overrun
);
    logic [IDX_W-1:0] idx;
    logic             last;

    // Last word of a burst is going out on this edge.
    always_comb last = busy && (idx == IDX_W'(LANES-1));
    // Take a start when idle or when the final word leaves now.
    always_comb accept = start && (!busy || last);

    // Burst state, output word, strobe and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            idx      <= '0;
            bus_we   <= 1'b0;
            bus_data <= '0;
            overrun  <= 1'b0;
        end else begin
            bus_we <= busy;
            if (busy) bus_data <= held[idx];
            if (accept) begin
                busy <= 1'b1;
                idx  <= '0;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    idx  <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
            if (start && !accept) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/audio_lane_mux.sv
// Module: top level. LANES serial lanes share one bit clock and one word
// clock; every word-clock edge latches all lanes, and the sequencer then
// sends them over one strobed 16-bit bus.
// Assumes 4 <= LANES <= 16 and word-clock halves of at least LANES bit clocks.
module audio_lane_mux
    import amux_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wclk,
    input  logic [LANES-1:0] sdata,
    output logic [WORD_W-1:0] bus_data,
    output logic             bus_we,
    output logic             overrun
);
    logic              start_pulse;
    logic              accept;
    logic              seq_busy;
    word_t [LANES-1:0] held;

    amux_edge_pulse u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .wclk  (wclk),
        .start (start_pulse)
    );

    // One shifter per lane, all capturing on the accepted start.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        amux_lane_shifter u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .sdata   (sdata[g]),
            .capture (accept),
            .held    (held[g])
        );
    end

    amux_sequencer #(.LANES(LANES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_pulse),
        .held     (held),
        .accept   (accept),
        .busy     (seq_busy),
        .bus_data (bus_data),
        .bus_we   (bus_we),
        .overrun  (overrun)
    );
endmodule

// File: rtl/amux_checker.sv
// Module: protocol checker for audio_lane_mux, attached with bind.
module amux_checker #(
    parameter int unsigned LANES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic accept,
    input logic busy,
    input logic bus_we,
    input logic overrun
);
    // R2: an accepted start puts the sequencer into a burst
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    // R3: every busy cycle produces a strobed word on the next cycle
    a_r3_busy_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> bus_we);
    // R4: no strobe follows an idle cycle
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !bus_we);
    // R5: a start that finds the sequencer idle is always taken
    a_r5_idle_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> accept);
    // R6: a refused start raises overrun
    a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !accept) |=> overrun);
    // R6: overrun holds until reset
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind audio_lane_mux amux_checker #(.LANES(LANES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_pulse),
    .accept  (accept),
    .busy    (seq_busy),
    .bus_we  (bus_we),
    .overrun (overrun)
);

// File: tb/test_audio_lane_mux.sv
module test_audio_lane_mux;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wclk = 1'b0;
    logic [N-1:0] sdata = '0;
    logic [15:0]  bus_data;
    logic         bus_we;
    logic         overrun;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [15:0] exp_q[$];
    int          expc_q[$];
    logic [15:0] hist[N];
    logic [31:0] seed = 32'h1234_5678;
    bit          have_acc = 0;
    int          last_acc = 0;
    bit          exp_ovr = 0;

    audio_lane_mux #(.LANES(N)) i_audio_lane_mux (
        .clk(clk), .rst_n(rst_n), .wclk(wclk), .sdata(sdata),
        .bus_data(bus_data), .bus_we(bus_we), .overrun(overrun)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    // Driver: one bit-clock cycle of stimulus; models the expected words.
    task automatic drive_cycle(input logic lvl);
        @(negedge clk);
        if (lvl != wclk) begin
            // R1/R5/R6: toggle sampled at edge cyc+1
            if (!have_acc || (cyc - last_acc) >= N) begin
                for (int i = 0; i < N; i++) begin
                    exp_q.push_back(hist[i]);
                    expc_q.push_back(cyc + 2 + i);  // R3 timing
                end
                have_acc = 1;
                last_acc = cyc;
            end else begin
                exp_ovr = 1;
            end
        end
        wclk = lvl;
        seed = nxt(seed);
        for (int i = 0; i < N; i++) begin
            sdata[i] = seed[8 + i];
            hist[i] = {hist[i][14:0], seed[8 + i]};
        end
    endtask

    task automatic drive_half(input logic lvl, input int len);
        for (int c = 0; c < len; c++) drive_cycle(lvl);
    endtask

    // Monitor: pop and compare each strobed word.
    always @(negedge clk) begin
        if (rst_n && bus_we) begin
            if (exp_q.size() == 0) begin
                check(0, "R4 extra strobe", bus_data, 0);
            end else begin
                logic [15:0] e;
                int ec;
                e = exp_q.pop_front();
                ec = expc_q.pop_front();
                check(bus_data == e, "R1/R2 word", bus_data, e);
                check(cyc == ec, "R3 strobe cycle", cyc, ec);
            end
        end
    end

    initial begin
        for (int i = 0; i < N; i++) hist[i] = '0;
        repeat (3) @(negedge clk);
        check(bus_we == 0 && overrun == 0 && bus_data == 0, "R7 reset state",
              {bus_we, overrun, bus_data}, 0);
        rst_n = 1'b1;
        // R1: both edges, full 16-bit halves
        drive_half(1'b1, 20);
        drive_half(1'b0, 20);
        drive_half(1'b1, 16);
        drive_half(1'b0, 17);
        // R5: halves exactly N long -> back-to-back bursts
        drive_half(1'b1, N);
        drive_half(1'b0, N);
        drive_half(1'b1, 18);
        check(overrun == 0, "R5 no overrun at exact spacing", overrun, 0);
        // R6: a start too soon is dropped
        drive_half(1'b0, 2);
        drive_half(1'b1, 18);
        drive_half(1'b0, 16);
        drive_half(1'b0, 2 * N + 4);
        check(overrun == exp_ovr, "R6 overrun set", overrun, exp_ovr);
        check(exp_q.size() == 0, "R4 all words delivered", exp_q.size(), 0);
        // R7: reset clears overrun and output
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(overrun == 0 && bus_we == 0 && bus_data == 0, "R7 reset clears",
              {overrun, bus_we, bus_data}, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule